// File: doc/BRIEF.md
# Clock Source Mode Controller

This block is the control state machine for an on-chip clock generator. It works out which of seven operating modes the generator is in and drives the control lines that follow from that mode. The mode comes from five control bits: a reference-select bit (internal or external reference), a two-bit clock-source field, a low-power request and a debug-active flag. The block drives the select of the output clock multiplexer, the enable of the frequency-locked loop (FLL) and the enable of the internal reference. The oscillator, the loop filter and the FLL itself are outside the block. Only their enables, the clock select and an FLL lock-status input appear at its boundary.

All control inputs, including the stop request, pass through one register stage. The mode register then reads those registered controls on every clock, so a change at the inputs shows on the mode outputs two rising edges later. A stop request sends the block into the stop mode from any mode and records the mode that was running. When the request is released, the block returns to that recorded mode. A reset received while in stop discards the record.

Top module: `clkmode_ctrl`

## Requirements
- R1: While reset is asserted (asynchronous, active low), the mode is FLL-engaged-internal (code 0), clk_sel_o is 00, and fll_en_o and iref_en_o are both 1.
- R2: With clock-source field 00, the mode becomes FLL-engaged-internal (code 0) if reference select is 1, or FLL-engaged-external (code 1) if it is 0. The new mode appears on the second rising edge after the inputs change.
- R3: Clock-source field 01 with reference select 1 gives bypassed-internal-low-power (code 3) when low power is 1 and debug is 0. In every other case of low power and debug it gives bypassed-internal (code 2).
- R4: Clock-source field 10 with reference select 0 gives bypassed-external-low-power (code 5) when low power is 1 and debug is 0. In every other case it gives bypassed-external (code 4).
- R5: Some control combinations leave the mode unchanged: field 11, field 01 with reference select 0, and field 10 with reference select 1.
- R6: A stop request moves the block to stop (code 6) two rising edges later, from any mode. The block stays in stop for as long as the request is held, whatever the other controls do. In stop, clk_sel_o is 11 and fll_en_o, iref_en_o and clk_ok_o are all 0.
- R7: When the stop request is released, the mode returns to the mode that was active before stop, on the second rising edge after release. From the next edge on, the mode is again decoded from the current controls.
- R8: A reset asserted during stop puts the block in FLL-engaged-internal. After reset, the mode saved before stop is never restored.
- R9: fll_en_o is 0 exactly in codes 3, 5 and 6, and 1 in every other mode.
- R10: iref_en_o is 1 exactly in codes 0, 2 and 3. clk_sel_o is 00 in the engaged modes, 01 in the internal bypass modes, 10 in the external bypass modes and 11 in stop.
- R11: clk_ok_o follows fll_lock_i in the engaged modes (codes 0 and 1). It is 1 in the bypass modes (codes 2 to 5) and 0 in stop.
- R12: mode_vld_o is 0 during reset and 1 from the first rising edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_int_i | input | 1 | Reference select: 1 internal, 0 external |
| src_sel_i | input | 2 | Clock-source field: 00 FLL, 01 internal reference, 10 external reference, 11 reserved |
| lp_req_i | input | 1 | Low-power request for the bypass modes |
| dbg_act_i | input | 1 | Debug link active |
| stop_req_i | input | 1 | Stop request |
| fll_lock_i | input | 1 | Lock status from the FLL |
| mode_o | output | 3 | Current mode code, 0 to 6 |
| mode_vld_o | output | 1 | Mode code valid |
| clk_sel_o | output | 2 | Output clock multiplexer select |
| fll_en_o | output | 1 | FLL enable |
| iref_en_o | output | 1 | Internal reference enable |
| clk_ok_o | output | 1 | Selected output clock usable |

## Verification
The hardest case is the return from stop. Whether the block goes back to the saved mode, rather than simply decoding the current inputs, can only be seen if the controls change while stop is held. The bench enters stop from each of the six running modes and, during stop, switches the controls to a different mode. It then checks the restored mode on the exact cycle of return and the newly decoded mode one edge later. A reset applied inside stop, with the controls parked on a reserved code so that they hold the mode, shows that the saved mode is dropped.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;

  localparam int MODE_W = 3;
  localparam int SEL_W  = 2;

  typedef enum logic [MODE_W-1:0] {
    MD_ENG_INT    = 3'd0,
    MD_ENG_EXT    = 3'd1,
    MD_BYP_INT    = 3'd2,
    MD_BYP_INT_LP = 3'd3,
    MD_BYP_EXT    = 3'd4,
    MD_BYP_EXT_LP = 3'd5,
    MD_STOP       = 3'd6
  } mode_e;

  typedef struct packed {
    logic             ref_int;
    logic [SEL_W-1:0] src;
    logic             lp;
    logic             dbg;
    logic             stop;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);

  localparam logic [SEL_W-1:0] SRC_FLL  = 2'b00;
  localparam logic [SEL_W-1:0] SRC_INT  = 2'b01;
  localparam logic [SEL_W-1:0] SRC_EXT  = 2'b10;
  localparam logic [SEL_W-1:0] SRC_NONE = 2'b11;

  // Low-power bypass is granted only with debug idle.
  function automatic logic lp_granted(ctl_t c);
    return c.lp && !c.dbg;
  endfunction

  // Next running mode from registered controls; illegal combos hold.
  function automatic mode_e decode_mode(ctl_t c, mode_e cur);
    mode_e nxt;
    nxt = cur;
    unique case (c.src)
      SRC_FLL: nxt = c.ref_int ? MD_ENG_INT : MD_ENG_EXT;
      SRC_INT: if (c.ref_int)
                 nxt = lp_granted(c) ? MD_BYP_INT_LP : MD_BYP_INT;
      SRC_EXT: if (!c.ref_int)
                 nxt = lp_granted(c) ? MD_BYP_EXT_LP : MD_BYP_EXT;
      default: nxt = cur;
    endcase
    return nxt;
  endfunction

  function automatic logic [SEL_W-1:0] mux_sel(mode_e m);
    case (m)
      MD_ENG_INT, MD_ENG_EXT:       return SRC_FLL;
      MD_BYP_INT, MD_BYP_INT_LP:    return SRC_INT;
      MD_BYP_EXT, MD_BYP_EXT_LP:    return SRC_EXT;
      default:                      return SRC_NONE;
    endcase
  endfunction

  function automatic logic fll_on(mode_e m);
    return !(m == MD_BYP_INT_LP || m == MD_BYP_EXT_LP || m == MD_STOP);
  endfunction

  function automatic logic iref_on(mode_e m);
    return (m == MD_ENG_INT || m == MD_BYP_INT || m == MD_BYP_INT_LP);
  endfunction

  function automatic logic is_engaged(mode_e m);
    return (m == MD_ENG_INT || m == MD_ENG_EXT);
  endfunction

endpackage

// File: rtl/clkmode_inreg.sv
module clkmode_inreg #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rst_val,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= rst_val;
    else        q <= d;
  end
endmodule

// File: rtl/clkmode_fsm.sv
module clkmode_fsm
  import clkmode_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  ctl_t  ctl_q,
  output mode_e mode_q,
  output mode_e saved_q,
  output logic  vld_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MD_ENG_INT;
      saved_q <= MD_ENG_INT;
      vld_q   <= 1'b0;
    end else begin
      vld_q <= 1'b1;
      if (ctl_q.stop) begin
        if (mode_q != MD_STOP) begin
          saved_q <= mode_q;
          mode_q  <= MD_STOP;
        end
      end else if (mode_q == MD_STOP) begin
        mode_q <= saved_q;
      end else begin
        mode_q <= decode_mode(ctl_q, mode_q);
      end
    end
  end
endmodule

// File: rtl/clkmode_outdec.sv
module clkmode_outdec
  import clkmode_pkg::*;
(
  input  mode_e            mode,
  input  logic             lock,
  output logic [SEL_W-1:0] clk_sel,
  output logic             fll_en,
  output logic             iref_en,
  output logic             clk_ok
);
  always_comb begin
    clk_sel = mux_sel(mode);
    fll_en  = fll_on(mode);
    iref_en = iref_on(mode);
    if (is_engaged(mode))      clk_ok = lock;
    else if (mode == MD_STOP)  clk_ok = 1'b0;
    else                       clk_ok = 1'b1;
  end
endmodule

// File: rtl/clkmode_ctrl.sv
module clkmode_ctrl
  import clkmode_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_int_i,
  input  logic [1:0] src_sel_i,
  input  logic       lp_req_i,
  input  logic       dbg_act_i,
  input  logic       stop_req_i,
  input  logic       fll_lock_i,
  output logic [2:0] mode_o,
  output logic       mode_vld_o,
  output logic [1:0] clk_sel_o,
  output logic       fll_en_o,
  output logic       iref_en_o,
  output logic       clk_ok_o
);
  ctl_t              ctl_d, ctl_q, ctl_rst;
  logic [CTL_W-1:0]  ctl_q_raw;
  mode_e             mode_q, saved_q;
  logic              vld_q;

  // Named internal events for the checker.
  logic stop_enter, stop_exit, hold_evt;

  assign ctl_d   = '{ref_int: ref_int_i, src: src_sel_i, lp: lp_req_i,
                     dbg: dbg_act_i, stop: stop_req_i};
  assign ctl_rst = '{ref_int: 1'b1, src: SRC_FLL, lp: 1'b0,
                     dbg: 1'b0, stop: 1'b0};

  clkmode_inreg #(.W(CTL_W)) u_inreg (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_val (ctl_rst),
    .d       (ctl_d),
    .q       (ctl_q_raw)
  );
  assign ctl_q = ctl_t'(ctl_q_raw);

  clkmode_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctl_q   (ctl_q),
    .mode_q  (mode_q),
    .saved_q (saved_q),
    .vld_q   (vld_q)
  );

  clkmode_outdec u_outdec (
    .mode    (mode_q),
    .lock    (fll_lock_i),
    .clk_sel (clk_sel_o),
    .fll_en  (fll_en_o),
    .iref_en (iref_en_o),
    .clk_ok  (clk_ok_o)
  );

  assign stop_enter = ctl_q.stop && (mode_q != MD_STOP);
  assign stop_exit  = !ctl_q.stop && (mode_q == MD_STOP);
  assign hold_evt   = !ctl_q.stop && (mode_q != MD_STOP) &&
                      (decode_mode(ctl_q, MD_STOP) == MD_STOP);

  assign mode_o     = mode_q;
  assign mode_vld_o = vld_q;
endmodule

// File: rtl/clkmode_ctrl_chk.sv
module clkmode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       stop_enter,
  input logic       stop_exit,
  input logic       hold_evt,
  input logic [2:0] saved,
  input logic [2:0] mode_o,
  input logic       mode_vld_o,
  input logic [1:0] clk_sel_o,
  input logic       fll_en_o,
  input logic       iref_en_o,
  input logic       clk_ok_o
);
  p_stop_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_enter |=> (mode_o == 3'd6));

  p_stop_outputs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd6) |-> (clk_sel_o == 2'b11 && !fll_en_o && !iref_en_o && !clk_ok_o));

  p_restore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_exit |=> (mode_o == $past(saved)));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hold_evt |=> $stable(mode_o));

  p_lp_fll_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd3 || mode_o == 3'd5) |-> !fll_en_o);

  p_vld_r12: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> mode_vld_o);

  p_code_range_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o != 3'd7);
endmodule

bind clkmode_ctrl clkmode_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .stop_enter (stop_enter),
  .stop_exit  (stop_exit),
  .hold_evt   (hold_evt),
  .saved      (saved_q),
  .mode_o     (mode_o),
  .mode_vld_o (mode_vld_o),
  .clk_sel_o  (clk_sel_o),
  .fll_en_o   (fll_en_o),
  .iref_en_o  (iref_en_o),
  .clk_ok_o   (clk_ok_o)
);

// File: tb/clkmode_ctrl_tb.sv
module clkmode_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_int_i = 1'b1;
  logic [1:0] src_sel_i = 2'b00;
  logic       lp_req_i = 1'b0;
  logic       dbg_act_i = 1'b0;
  logic       stop_req_i = 1'b0;
  logic       fll_lock_i = 1'b0;
  logic [2:0] mode_o;
  logic       mode_vld_o;
  logic [1:0] clk_sel_o;
  logic       fll_en_o, iref_en_o, clk_ok_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  clkmode_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ref_int_i(ref_int_i), .src_sel_i(src_sel_i),
    .lp_req_i(lp_req_i), .dbg_act_i(dbg_act_i), .stop_req_i(stop_req_i),
    .fll_lock_i(fll_lock_i), .mode_o(mode_o), .mode_vld_o(mode_vld_o),
    .clk_sel_o(clk_sel_o), .fll_en_o(fll_en_o), .iref_en_o(iref_en_o),
    .clk_ok_o(clk_ok_o)
  );

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // Outputs expected for mode code m, computed arithmetically.
  task automatic chk_outputs(int m);
    chk("R10 clk_sel", clk_sel_o, m >> 1);
    chk("R9 fll_en", fll_en_o, (m == 3 || m == 5 || m == 6) ? 0 : 1);
    chk("R10 iref_en", iref_en_o, (m == 0 || m == 2 || m == 3) ? 1 : 0);
    chk("R11 clk_ok", clk_ok_o, (m < 2) ? int'(fll_lock_i) : ((m < 6) ? 1 : 0));
  endtask

  task automatic drive_mode(int m);
    lp_req_i  = (m == 3 || m == 5);
    dbg_act_i = 1'b0;
    case (m)
      0: begin ref_int_i = 1; src_sel_i = 2'b00; end
      1: begin ref_int_i = 0; src_sel_i = 2'b00; end
      2, 3: begin ref_int_i = 1; src_sel_i = 2'b01; end
      default: begin ref_int_i = 0; src_sel_i = 2'b10; end
    endcase
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int exp_m;
    @(negedge clk);
    // R1 reset state
    chk("R1 mode", mode_o, 0);
    chk("R1 clk_sel", clk_sel_o, 0);
    chk("R1 fll_en", fll_en_o, 1);
    chk("R1 iref_en", iref_en_o, 1);
    chk("R12 vld in reset", mode_vld_o, 0);
    step(1);
    rst_n = 1'b1;
    step(1);
    chk("R12 vld after reset", mode_vld_o, 1);

    // Sweep of every control combination, both directions.
    exp_m = 0;
    for (int pass = 0; pass < 2; pass++) begin
      for (int i = 0; i < 32; i++) begin
        int k;
        int sel;
        int r;
        int lpg;
        string tag;
        k = (pass == 0) ? i : 31 - i;
        r   = (k >> 4) & 1;
        sel = (k >> 2) & 3;
        lpg = ((k >> 1) & 1) * (1 - (k & 1));
        ref_int_i  = r[0];
        src_sel_i  = sel[1:0];
        lp_req_i   = k[1];
        dbg_act_i  = k[0];
        fll_lock_i = k[0] ^ pass[0];
        if (sel == 0) begin exp_m = 1 - r; tag = "R2"; end
        else if (sel == 1 && r == 1) begin exp_m = 2 + lpg; tag = "R3"; end
        else if (sel == 2 && r == 0) begin exp_m = 4 + lpg; tag = "R4"; end
        else tag = "R5";
        step(1);
        if (tag == "R5") chk("R5 hold early", mode_o, exp_m);
        step(1);
        chk(tag, mode_o, exp_m);
        chk_outputs(exp_m);
        chk("R12 vld", mode_vld_o, 1);
      end
    end

    // Lock follows in engaged mode, ignored in bypass.
    drive_mode(1); fll_lock_i = 0; step(2);
    chk("R11 engaged unlocked", clk_ok_o, 0);
    fll_lock_i = 1; #1;
    chk("R11 engaged locked", clk_ok_o, 1);
    drive_mode(4); fll_lock_i = 0; step(2);
    chk("R11 bypass", clk_ok_o, 1);

    // Stop from each running mode, controls changed during stop.
    for (int m = 0; m < 6; m++) begin
      int nm;
      nm = (m + 1) % 6;
      drive_mode(m); fll_lock_i = 1; step(2);
      chk("R6 pre-stop mode", mode_o, m);
      stop_req_i = 1'b1;
      step(1);
      chk("R6 not yet", mode_o, m);
      step(1);
      chk("R6 stop entry", mode_o, 6);
      chk_outputs(6);
      drive_mode(nm);
      step(3);
      chk("R6 held in stop", mode_o, 6);
      stop_req_i = 1'b0;
      step(1);
      chk("R7 still stop", mode_o, 6);
      step(1);
      chk("R7 restored", mode_o, m);
      chk_outputs(m);
      step(1);
      chk("R7 decode resumes", mode_o, nm);
    end

    // Reset while stopped drops the saved mode.
    drive_mode(4); step(2);
    stop_req_i = 1'b1; step(2);
    chk("R8 in stop", mode_o, 6);
    ref_int_i = 1; src_sel_i = 2'b11;
    rst_n = 1'b0; #1;
    chk("R8 reset in stop", mode_o, 0);
    stop_req_i = 1'b0;
    step(1);
    rst_n = 1'b1;
    step(3);
    chk("R8 no restore", mode_o, 0);
    chk_outputs(0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule